// File: doc/BRIEF.md
# Three-Step Scheduled Dataflow Evaluator

The block evaluates one fixed, branch-free dependency graph of five arithmetic operations on four 16-bit operands a, b, c and d. It produces two results: z = (a + b) + d and x3 = ((a * c) - d) + c. The operations are placed in three control steps as early as their operands allow. Every intermediate value is held in a register at a step boundary, so no operator is chained behind another inside a cycle.

A hardwired sequencer with one state per control step steers a shared datapath. The datapath has one multiplier and two add/subtract units, and the operand multiplexers in front of the adders let one unit serve a different operation in each step. A user pulses `start` for one cycle while the block is idle and waits for the one-cycle `done` pulse. Both results can then be read and stay put until the next accepted start.

Top module: `dfgScheduler`

## Requirements
- R1: After a run, `zOut` equals (a + b + d) mod 2^16 and `x3Out` equals ((a * c) mod 2^16 - d + c) mod 2^16, computed from the operands sampled at the accepted start.
- R2: Step 1 forms a+b and a*c, step 2 forms z and a*c-d from those registered values, and step 3 forms x3. `zOut` therefore takes its new value one cycle before `x3Out`.
- R3: When a start is accepted at clock edge k, the sequencer passes through exactly three step states and `done` is high in the cycle after edge k+3.
- R4: A start pulse that arrives while a run is in progress is ignored. It neither restarts the run nor resamples the operands, and it produces no extra done pulse.
- R5: `zOut` and `x3Out` hold their values from the done pulse until the next accepted start, whatever happens on the operand inputs.
- R6: `done` is high for exactly one cycle per run.
- R7: While synchronous active-high `rst` is asserted, the sequencer goes idle, `done` is low, and `zOut` and `x3Out` are 0.
- R8: A start that coincides with the done cycle is accepted, so runs can follow each other with no gap cycle.
- R9: The product keeps only its low 16 bits, and addition and subtraction wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a run; only honoured while idle |
| aIn | input | 16 | Operand a |
| bIn | input | 16 | Operand b |
| cIn | input | 16 | Operand c |
| dIn | input | 16 | Operand d |
| zOut | output | 16 | Result z = a + b + d |
| x3Out | output | 16 | Result x3 = a*c - d + c |
| done | output | 1 | One-cycle pulse when both results are valid |

## Verification
The bench sends start pulses into every busy step. A design that restarted or resampled on those pulses would give the wrong results or a second done pulse. Operands are changed in every cycle after the start, which exposes a design that reads the live inputs instead of its sampled copies, or that lets the outputs drift while idle. Back-to-back starts placed on the done cycle catch a sequencer that needs an idle gap. Operands near full scale check the wrap of the sums and the truncation of the product, and the cycle-exact comparison of `zOut` catches a datapath that moves z into the wrong step.

// File: rtl/dfgPkg.sv
package dfgPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP1 = 2'd1,
    ST_STEP2 = 2'd2,
    ST_STEP3 = 2'd3
  } seqState_t;

  // operand pair routed into a shared add/sub unit
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AB   = 3'd1,
    SRC_X1D  = 3'd2,
    SRC_YD   = 3'd3,
    SRC_X2C  = 3'd4
  } opSrc_t;

  localparam int NUM_ADDSUB = 2;

  typedef struct packed {
    logic   loadIn;
    logic   capStep1;
    logic   capStep2;
    logic   capStep3;
    opSrc_t unit0Src;
    logic   unit0Sub;
    opSrc_t unit1Src;
    logic   unit1Sub;
  } dfgCtrl_t;

endpackage

// File: rtl/dfgAddSub.sv
module dfgAddSub #(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         sub,
  output logic [W-1:0] res
);

  always_comb begin
    if (sub) res = opA - opB;
    else     res = opA + opB;
  end

endmodule

// File: rtl/dfgControl.sv
module dfgControl
  import dfgPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  output dfgCtrl_t ctrl,
  output logic     done
);

  seqState_t state;
  seqState_t stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (start) stateNext = ST_STEP1;
      ST_STEP1: stateNext = ST_STEP2;
      ST_STEP2: stateNext = ST_STEP3;
      ST_STEP3: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_STEP3);
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.unit0Src = SRC_NONE;
    ctrl.unit1Src = SRC_NONE;
    case (state)
      ST_IDLE: ctrl.loadIn = start;
      ST_STEP1: begin
        ctrl.capStep1 = 1'b1;
        ctrl.unit0Src = SRC_AB;
      end
      ST_STEP2: begin
        ctrl.capStep2 = 1'b1;
        ctrl.unit0Src = SRC_X1D;
        ctrl.unit1Src = SRC_YD;
        ctrl.unit1Sub = 1'b1;
      end
      ST_STEP3: begin
        ctrl.capStep3 = 1'b1;
        ctrl.unit0Src = SRC_X2C;
      end
      default: ctrl.loadIn = 1'b0;
    endcase
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !ctrl.loadIn); // R4

  AST_STEP_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STEP1) |=> (state == ST_STEP2)); // R3

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state == ST_STEP3)); // R3

endmodule

// File: rtl/dfgDatapath.sv
module dfgDatapath
  import dfgPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  dfgCtrl_t     ctrl,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] cIn,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] zOut,
  output logic [W-1:0] x3Out
);

  logic [W-1:0] aR, bR, cR, dR;
  logic [W-1:0] x1R, yR, x2R;
  logic [W-1:0] prod;

  logic [W-1:0] unitA   [NUM_ADDSUB];
  logic [W-1:0] unitB   [NUM_ADDSUB];
  logic         unitSub [NUM_ADDSUB];
  logic [W-1:0] unitY   [NUM_ADDSUB];
  opSrc_t       unitSrc [NUM_ADDSUB];

  assign unitSrc[0] = ctrl.unit0Src;
  assign unitSrc[1] = ctrl.unit1Src;
  assign unitSub[0] = ctrl.unit0Sub;
  assign unitSub[1] = ctrl.unit1Sub;

  assign prod = aR * cR;

  for (genvar u = 0; u < NUM_ADDSUB; u++) begin : g_unit
    always_comb begin
      case (unitSrc[u])
        SRC_AB:  begin unitA[u] = aR;  unitB[u] = bR; end
        SRC_X1D: begin unitA[u] = x1R; unitB[u] = dR; end
        SRC_YD:  begin unitA[u] = yR;  unitB[u] = dR; end
        SRC_X2C: begin unitA[u] = x2R; unitB[u] = cR; end
        default: begin unitA[u] = '0;  unitB[u] = '0; end
      endcase
    end

    dfgAddSub #(.W(W)) i_addSub (
      .opA (unitA[u]),
      .opB (unitB[u]),
      .sub (unitSub[u]),
      .res (unitY[u])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aR <= '0; bR <= '0; cR <= '0; dR <= '0;
      x1R <= '0; yR <= '0; x2R <= '0;
      zOut <= '0; x3Out <= '0;
    end else begin
      if (ctrl.loadIn) begin
        aR <= aIn; bR <= bIn; cR <= cIn; dR <= dIn;
      end
      if (ctrl.capStep1) begin
        x1R <= unitY[0];
        yR  <= prod;
      end
      if (ctrl.capStep2) begin
        zOut <= unitY[0];
        x2R  <= unitY[1];
      end
      if (ctrl.capStep3) x3Out <= unitY[0];
    end
  end

  AST_STEP2_NEEDS_STEP1: assert property (@(posedge clk) disable iff (rst)
    ctrl.capStep2 |-> $past(ctrl.capStep1)); // R2

  AST_STEP3_NEEDS_STEP2: assert property (@(posedge clk) disable iff (rst)
    ctrl.capStep3 |-> $past(ctrl.capStep2)); // R2

  AST_Z_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capStep2 |=> $stable(zOut)); // R5

  AST_X3_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capStep3 |=> $stable(x3Out)); // R5

endmodule

// File: rtl/dfgScheduler.sv
module dfgScheduler
  import dfgPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] cIn,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] zOut,
  output logic [W-1:0] x3Out,
  output logic         done
);

  dfgCtrl_t ctrl;

  dfgControl i_control (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctrl  (ctrl),
    .done  (done)
  );

  dfgDatapath #(.W(W)) i_datapath (
    .clk   (clk),
    .rst   (rst),
    .ctrl  (ctrl),
    .aIn   (aIn),
    .bIn   (bIn),
    .cIn   (cIn),
    .dIn   (dIn),
    .zOut  (zOut),
    .x3Out (x3Out)
  );

endmodule

// File: tb/test_dfgScheduler.sv
`timescale 1ns/1ps
module test_dfgScheduler;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] aIn = '0, bIn = '0, cIn = '0, dIn = '0;
  logic [15:0] zOut, x3Out;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  int mCnt = 0;
  int mA, mB, mC, mD;
  int mZ = 0, mX3 = 0;
  bit mDone = 0;
  int doneCount = 0;

  always #2.5 clk = ~clk;

  dfgScheduler i_dfgScheduler (
    .clk (clk), .rst (rst), .start (start),
    .aIn (aIn), .bIn (bIn), .cIn (cIn), .dIn (dIn),
    .zOut (zOut), .x3Out (x3Out), .done (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: step counter and wrapped integer arithmetic
  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mDone = 0; mZ = 0; mX3 = 0;
    end else begin
      mDone = 0;
      if (mCnt == 0) begin
        if (start) begin
          mA = aIn; mB = bIn; mC = cIn; mD = dIn;
          mCnt = 1;
        end
      end else if (mCnt == 1) begin
        mCnt = 2;
      end else if (mCnt == 2) begin
        mZ = (mA + mB + mD) & 16'hFFFF;
        mCnt = 3;
      end else begin
        mX3 = ((((mA * mC) & 16'hFFFF) - mD + mC)) & 16'hFFFF;
        mDone = 1;
        mCnt = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (done) doneCount++;
    if (!rst) begin
      chk(done == mDone, "R3/R6 done timing", done, mDone);
      chk(zOut == 16'(mZ), "R2 z value and step", zOut, mZ);
      chk(x3Out == 16'(mX3), "R1 x3 value", x3Out, mX3);
    end
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic pulseStart(input logic [15:0] a, b, c, d);
    @(negedge clk);
    aIn = a; bIn = b; cIn = c; dIn = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  initial begin
    int dc0;
    logic [15:0] zHeld, x3Held;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(done == 1'b0, "R7 done low in reset", done, 0);
    chk(zOut == 16'd0, "R7 z cleared", zOut, 0);
    chk(x3Out == 16'd0, "R7 x3 cleared", x3Out, 0);
    rst = 1'b0;

    // R1 basic run
    pulseStart(16'd3, 16'd4, 16'd5, 16'd6);
    waitDone();
    chk(zOut == 16'd13, "R1 z=a+b+d", zOut, 13);
    chk(x3Out == 16'd14, "R1 x3=a*c-d+c", x3Out, 14);

    // R9 wrap and truncation
    pulseStart(16'hFFFF, 16'h0002, 16'h1234, 16'h5678);
    waitDone();
    chk(zOut == 16'h5679, "R9 sum wraps", zOut, 16'h5679);
    chk(x3Out == 16'(((16'hFFFF * 16'h1234) & 16'hFFFF) - 16'h5678 + 16'h1234),
        "R9 product truncated", x3Out,
        16'(((16'hFFFF * 16'h1234) & 16'hFFFF) - 16'h5678 + 16'h1234));

    // R5 hold while idle with toggling operands
    zHeld = zOut; x3Held = x3Out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      aIn = 16'(i * 777); bIn = ~aIn; cIn = 16'(i); dIn = 16'hA5A5;
    end
    chk(zOut == zHeld, "R5 z held", zOut, zHeld);
    chk(x3Out == x3Held, "R5 x3 held", x3Out, x3Held);

    // R4 busy starts ignored, operands change during run
    dc0 = doneCount;
    @(negedge clk);
    aIn = 16'd10; bIn = 16'd20; cIn = 16'd30; dIn = 16'd40; start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      aIn = 16'(100 + i); bIn = 16'(200 + i); cIn = 16'(300 + i); dIn = 16'(400 + i);
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(doneCount - dc0 == 1, "R4 one done for busy starts", doneCount - dc0, 1);
    chk(zOut == 16'd70, "R4 operands not resampled z", zOut, 70);
    chk(x3Out == 16'd290, "R4 operands not resampled x3", x3Out, 290);

    // R8 back-to-back: start on the done cycle
    pulseStart(16'd1, 16'd1, 16'd1, 16'd1);
    waitDone();
    aIn = 16'd2; bIn = 16'd3; cIn = 16'd4; dIn = 16'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dc0 = doneCount;
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R8 second done after three steps", done, 1);
    chk(zOut == 16'd10, "R8 second z", zOut, 10);
    chk(x3Out == 16'd7, "R8 second x3", x3Out, 7);

    // R6 single-cycle done
    @(negedge clk);
    chk(done == 1'b0, "R6 done drops", done, 0);

    // R7 reset mid-run
    pulseStart(16'd9, 16'd9, 16'd9, 16'd9);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(zOut == 16'd0 && done == 1'b0, "R7 reset mid-run", zOut, 0);
    repeat (6) @(negedge clk);
    chk(done == 1'b0, "R7 no done after reset", done, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule